// File: doc/BRIEF.md
# Low-Toggle Bubble-Insertion Pipeline Registers

This block holds the three inter-stage registers of a five-stage in-order pipeline: decode/execute, execute/memory and memory/writeback. It also holds the load-use hazard detector that decides when a bubble must be placed between a load and its consumer. Every register is split in two. A small critical part holds the register write, memory write and memory read enables, plus the load-enable bits riding down the pipe. This part is captured on every edge. A wide part holds operands, register numbers, the ALU opcode and results. It is captured only when that register's load enable is high.

A bubble, or an empty decode slot, clears the critical part of the decode/execute register and leaves the wide part holding the previous instruction. It also launches two low load-enable bits that travel alongside the dead slot. The execute/memory and memory/writeback registers then also skip their wide capture when the slot reaches them. A dead slot therefore toggles no wide flops anywhere. Any activity at the execute inputs, for example when a forwarded operand changes, stops at the next register.

The ALU and the data memory sit outside the block. Their results come back in through `exResult` and `memRdata`. During a stall the fetch logic holds the program counter and the decode register, and the same instruction is presented again on the next cycle. Each register reports how many of its wide-part bits changed at the last edge.

Top module: `lt_bubble_pipe`

## Requirements
- R1: `stall` is high in the same cycle whenever `decValid` is high and the decode/execute register holds a load (register write and memory read both set) whose destination equals a source register of the decoding instruction. A source counts only if its use flag is set. In every other case `stall` is low.
- R2: A stall lasts exactly one cycle. The cycle after `stall` is high, `stall` is low, and the held instruction issues.
- R3: On an edge where `stall` is high or `decValid` is low, the decode/execute register write, memory write and memory read enables become 0.
- R4: On such an edge, the decode/execute opcode, destination, sources and operands keep their previous values, and `idexTog` reads 0.
- R5: One edge after a dead slot, the execute/memory register shows `exmTog` = 0 with its write enables 0. One edge after that, the memory/writeback register shows `wbTog` = 0 with `wbRegWe` = 0.
- R6: Each execute operand comes from the first match in this order:
  - the execute/memory result, if that stage writes a register, is not a load, and its destination matches the source;
  - otherwise the writeback data, if that stage writes a matching register;
  - otherwise the decoded operand.
- R7: The register writes (destination, value) appearing at `wbRegWe`, and the stores (address `exmResult`, data `exmStoreData`) appearing at `exmMemWe`, equal those of a sequential, one-at-a-time execution of the same instruction stream, in the same order.
- R8: While `rstN` is low, every critical enable clears to 0, every wide field clears to 0 and every toggle count reads 0.
- R9: `idexTog` equals the number of decode/execute wide-field bits, laid out as {opcode, destination, source 1, source 2, operand A, operand B}, that changed at the last edge.
- R10: An empty decode slot (`decValid` low) never raises `stall`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| decValid | input | 1 | Decode holds an instruction |
| decRegWe | input | 1 | Instruction writes a register |
| decMemWe | input | 1 | Instruction stores to memory |
| decMemRe | input | 1 | Instruction loads from memory |
| decUseRs1 | input | 1 | Source 1 is read |
| decUseRs2 | input | 1 | Source 2 is read |
| decAluOp | input | OPW | ALU opcode |
| decRd | input | RW | Destination register |
| decRs1 | input | RW | Source register 1 |
| decRs2 | input | RW | Source register 2 |
| decOpA | input | XW | Operand read for source 1 |
| decOpB | input | XW | Operand read for source 2 |
| exResult | input | XW | ALU result for the execute stage |
| memRdata | input | XW | Memory read data for the memory stage |
| stall | output | 1 | Hold fetch and decode this cycle |
| exOpA | output | XW | Forwarded execute operand A |
| exOpB | output | XW | Forwarded execute operand B |
| idexRegWe | output | 1 | Decode/execute register write enable |
| idexMemWe | output | 1 | Decode/execute memory write enable |
| idexMemRe | output | 1 | Decode/execute memory read enable |
| idexAluOp | output | OPW | Decode/execute opcode |
| idexRd | output | RW | Decode/execute destination |
| idexRs1 | output | RW | Decode/execute source 1 |
| idexRs2 | output | RW | Decode/execute source 2 |
| exmRegWe | output | 1 | Execute/memory register write enable |
| exmMemWe | output | 1 | Execute/memory memory write enable |
| exmMemRe | output | 1 | Execute/memory memory read enable |
| exmRd | output | RW | Execute/memory destination |
| exmResult | output | XW | Execute/memory result or address |
| exmStoreData | output | XW | Execute/memory store data |
| wbRegWe | output | 1 | Writeback register write enable |
| wbRd | output | RW | Writeback destination |
| wbData | output | XW | Writeback value |
| idexTog | output | TOGW | Wide-field bit changes, decode/execute |
| exmTog | output | TOGW | Wide-field bit changes, execute/memory |
| wbTog | output | TOGW | Wide-field bit changes, memory/writeback |

## Verification
The stream opens with directed pairs. Each pair is a load followed by a consumer:
- using the load's destination through source 1, and through source 2 (these tell apart the two compare paths of the hazard detector);
- carrying that register number only in an unused source field (shows that the use flags gate the compare);
- fully independent (shows no false stall);
- a store whose data depends on the load;
- a chain of three dependent loads (shows that a bubble can never repeat for one instruction).

Empty decode slots placed next to real instructions separate the idle hold from the hazard hold.

A long pseudo-random mix of ALU, load and store instructions over eight registers then exercises every forwarding distance. Its writebacks and stores are compared against a sequential model. Per-cycle toggle counts confirm that dead slots switch no wide flops in any of the three registers.

// File: rtl/bp_pkg.sv
package bp_pkg;

  // Strobes from the hazard control to the pipeline datapath.
  typedef struct packed {
    logic killCrit;  // force critical enables of the entering slot to 0
    logic leIdex;    // wide-part load enable of the decode/execute register
    logic leDown;    // load enable launched for the two downstream registers
  } strobeT;

endpackage

// File: rtl/bp_hazard_ctrl.sv
module bp_hazard_ctrl
  import bp_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          decValid,
  input  logic          decUseRs1,
  input  logic          decUseRs2,
  input  logic [RW-1:0] decRs1,
  input  logic [RW-1:0] decRs2,
  input  logic          idexRegWe,
  input  logic          idexMemRe,
  input  logic [RW-1:0] idexRd,
  output logic          stall,
  output strobeT        strobes
);

  logic loadInExe;
  logic hitRs1;
  logic hitRs2;
  logic loadUse;

  // A load sitting in execute cannot forward its data to the next instruction.
  assign loadInExe = idexRegWe & idexMemRe;
  assign hitRs1    = decUseRs1 & (decRs1 == idexRd);
  assign hitRs2    = decUseRs2 & (decRs2 == idexRd);
  assign loadUse   = decValid & loadInExe & (hitRs1 | hitRs2);

  assign stall = loadUse;

  always_comb begin
    strobes.killCrit = loadUse | ~decValid;
    strobes.leIdex   = ~strobes.killCrit;
    strobes.leDown   = ~strobes.killCrit;
  end

endmodule

// File: rtl/bp_split_reg.sv
module bp_split_reg #(
  parameter int             CW       = 1,
  parameter int             DW       = 8,
  parameter int             TOGW     = 8,
  parameter logic [CW-1:0]  CRIT_RST = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            le,
  input  logic [CW-1:0]   critD,
  input  logic [DW-1:0]   dataD,
  output logic [CW-1:0]   critQ,
  output logic [DW-1:0]   dataQ,
  output logic [TOGW-1:0] togCnt
);

  logic [DW-1:0] dataNext;

  assign dataNext = le ? dataD : dataQ;

  // Critical part: captured every edge.
  always_ff @(posedge clk) begin
    if (!rstN) critQ <= CRIT_RST;
    else       critQ <= critD;
  end

  // Wide part: captured only under the load enable.
  always_ff @(posedge clk) begin
    if (!rstN)   dataQ <= '0;
    else if (le) dataQ <= dataD;
  end

  // Number of wide-part bits that switch at this edge.
  always_ff @(posedge clk) begin
    if (!rstN) togCnt <= '0;
    else       togCnt <= TOGW'($countones(dataNext ^ dataQ));
  end

endmodule

// File: rtl/bp_datapath.sv
module bp_datapath
  import bp_pkg::*;
#(
  parameter int XW   = 32,
  parameter int RW   = 5,
  parameter int OPW  = 4,
  parameter int TOGW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobeT          strobes,
  input  logic            decRegWe,
  input  logic            decMemWe,
  input  logic            decMemRe,
  input  logic [OPW-1:0]  decAluOp,
  input  logic [RW-1:0]   decRd,
  input  logic [RW-1:0]   decRs1,
  input  logic [RW-1:0]   decRs2,
  input  logic [XW-1:0]   decOpA,
  input  logic [XW-1:0]   decOpB,
  input  logic [XW-1:0]   exResult,
  input  logic [XW-1:0]   memRdata,
  output logic [XW-1:0]   exOpA,
  output logic [XW-1:0]   exOpB,
  output logic            idexRegWe,
  output logic            idexMemWe,
  output logic            idexMemRe,
  output logic [OPW-1:0]  idexAluOp,
  output logic [RW-1:0]   idexRd,
  output logic [RW-1:0]   idexRs1,
  output logic [RW-1:0]   idexRs2,
  output logic            exmRegWe,
  output logic            exmMemWe,
  output logic            exmMemRe,
  output logic [RW-1:0]   exmRd,
  output logic [XW-1:0]   exmResult,
  output logic [XW-1:0]   exmStoreData,
  output logic            wbRegWe,
  output logic [RW-1:0]   wbRd,
  output logic [XW-1:0]   wbData,
  output logic [TOGW-1:0] idexTog,
  output logic [TOGW-1:0] exmTog,
  output logic [TOGW-1:0] wbTog
);

  localparam int IDEX_CW = 5;                 // regWe, memWe, memRe, leExm, leWb
  localparam int IDEX_DW = OPW + 3*RW + 2*XW;
  localparam int EXM_CW  = 4;                 // regWe, memWe, memRe, leWb
  localparam int EXM_DW  = RW + 2*XW;
  localparam int WB_CW   = 1;                 // regWe
  localparam int WB_DW   = RW + XW;

  // ---------------- decode / execute ----------------
  logic [IDEX_CW-1:0] idexCritD, idexCritQ;
  logic [IDEX_DW-1:0] idexDataD, idexDataQ;
  logic [XW-1:0]      idexOpA, idexOpB;
  logic               idexLeExm, idexLeWb;

  always_comb begin
    if (strobes.killCrit) idexCritD = {3'b000, strobes.leDown, strobes.leDown};
    else                  idexCritD = {decRegWe, decMemWe, decMemRe,
                                       strobes.leDown, strobes.leDown};
  end

  assign idexDataD = {decAluOp, decRd, decRs1, decRs2, decOpA, decOpB};

  bp_split_reg #(
    .CW(IDEX_CW), .DW(IDEX_DW), .TOGW(TOGW), .CRIT_RST(5'b00011)
  ) u_idex (
    .clk(clk), .rstN(rstN), .le(strobes.leIdex),
    .critD(idexCritD), .dataD(idexDataD),
    .critQ(idexCritQ), .dataQ(idexDataQ), .togCnt(idexTog)
  );

  assign {idexRegWe, idexMemWe, idexMemRe, idexLeExm, idexLeWb} = idexCritQ;
  assign {idexAluOp, idexRd, idexRs1, idexRs2, idexOpA, idexOpB} = idexDataQ;

  // ---------------- operand forwarding ----------------
  logic [RW-1:0] srcReg [2];
  logic [XW-1:0] rawOp  [2];
  logic [XW-1:0] fwdOp  [2];

  assign srcReg[0] = idexRs1;
  assign srcReg[1] = idexRs2;
  assign rawOp[0]  = idexOpA;
  assign rawOp[1]  = idexOpB;

  for (genvar k = 0; k < 2; k++) begin : g_fwd
    always_comb begin
      if (exmRegWe && !exmMemRe && (exmRd == srcReg[k])) fwdOp[k] = exmResult;
      else if (wbRegWe && (wbRd == srcReg[k]))           fwdOp[k] = wbData;
      else                                               fwdOp[k] = rawOp[k];
    end
  end

  assign exOpA = fwdOp[0];
  assign exOpB = fwdOp[1];

  // ---------------- execute / memory ----------------
  logic [EXM_CW-1:0] exmCritQ;
  logic [EXM_DW-1:0] exmDataQ;
  logic              exmLeWb;

  bp_split_reg #(
    .CW(EXM_CW), .DW(EXM_DW), .TOGW(TOGW), .CRIT_RST(4'b0001)
  ) u_exm (
    .clk(clk), .rstN(rstN), .le(idexLeExm),
    .critD({idexRegWe, idexMemWe, idexMemRe, idexLeWb}),
    .dataD({idexRd, exResult, exOpB}),
    .critQ(exmCritQ), .dataQ(exmDataQ), .togCnt(exmTog)
  );

  assign {exmRegWe, exmMemWe, exmMemRe, exmLeWb} = exmCritQ;
  assign {exmRd, exmResult, exmStoreData}        = exmDataQ;

  // ---------------- memory / writeback ----------------
  logic [WB_DW-1:0] wbDataQ;
  logic [XW-1:0]    wbValueD;

  assign wbValueD = exmMemRe ? memRdata : exmResult;

  bp_split_reg #(
    .CW(WB_CW), .DW(WB_DW), .TOGW(TOGW), .CRIT_RST(1'b0)
  ) u_wb (
    .clk(clk), .rstN(rstN), .le(exmLeWb),
    .critD(exmRegWe), .dataD({exmRd, wbValueD}),
    .critQ(wbRegWe), .dataQ(wbDataQ), .togCnt(wbTog)
  );

  assign {wbRd, wbData} = wbDataQ;

endmodule

// File: rtl/lt_bubble_pipe.sv
module lt_bubble_pipe
  import bp_pkg::*;
#(
  parameter int XW   = 32,
  parameter int RW   = 5,
  parameter int OPW  = 4,
  parameter int TOGW = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            decValid,
  input  logic            decRegWe,
  input  logic            decMemWe,
  input  logic            decMemRe,
  input  logic            decUseRs1,
  input  logic            decUseRs2,
  input  logic [OPW-1:0]  decAluOp,
  input  logic [RW-1:0]   decRd,
  input  logic [RW-1:0]   decRs1,
  input  logic [RW-1:0]   decRs2,
  input  logic [XW-1:0]   decOpA,
  input  logic [XW-1:0]   decOpB,
  input  logic [XW-1:0]   exResult,
  input  logic [XW-1:0]   memRdata,
  output logic            stall,
  output logic [XW-1:0]   exOpA,
  output logic [XW-1:0]   exOpB,
  output logic            idexRegWe,
  output logic            idexMemWe,
  output logic            idexMemRe,
  output logic [OPW-1:0]  idexAluOp,
  output logic [RW-1:0]   idexRd,
  output logic [RW-1:0]   idexRs1,
  output logic [RW-1:0]   idexRs2,
  output logic            exmRegWe,
  output logic            exmMemWe,
  output logic            exmMemRe,
  output logic [RW-1:0]   exmRd,
  output logic [XW-1:0]   exmResult,
  output logic [XW-1:0]   exmStoreData,
  output logic            wbRegWe,
  output logic [RW-1:0]   wbRd,
  output logic [XW-1:0]   wbData,
  output logic [TOGW-1:0] idexTog,
  output logic [TOGW-1:0] exmTog,
  output logic [TOGW-1:0] wbTog
);

  strobeT strobes;

  bp_hazard_ctrl #(.RW(RW)) u_ctrl (
    .decValid(decValid), .decUseRs1(decUseRs1), .decUseRs2(decUseRs2),
    .decRs1(decRs1), .decRs2(decRs2),
    .idexRegWe(idexRegWe), .idexMemRe(idexMemRe), .idexRd(idexRd),
    .stall(stall), .strobes(strobes)
  );

  bp_datapath #(.XW(XW), .RW(RW), .OPW(OPW), .TOGW(TOGW)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .decRegWe(decRegWe), .decMemWe(decMemWe), .decMemRe(decMemRe),
    .decAluOp(decAluOp), .decRd(decRd), .decRs1(decRs1), .decRs2(decRs2),
    .decOpA(decOpA), .decOpB(decOpB), .exResult(exResult), .memRdata(memRdata),
    .exOpA(exOpA), .exOpB(exOpB),
    .idexRegWe(idexRegWe), .idexMemWe(idexMemWe), .idexMemRe(idexMemRe),
    .idexAluOp(idexAluOp), .idexRd(idexRd), .idexRs1(idexRs1), .idexRs2(idexRs2),
    .exmRegWe(exmRegWe), .exmMemWe(exmMemWe), .exmMemRe(exmMemRe),
    .exmRd(exmRd), .exmResult(exmResult), .exmStoreData(exmStoreData),
    .wbRegWe(wbRegWe), .wbRd(wbRd), .wbData(wbData),
    .idexTog(idexTog), .exmTog(exmTog), .wbTog(wbTog)
  );

endmodule

// File: rtl/bp_checker.sv
module bp_checker #(
  parameter int XW   = 32,
  parameter int RW   = 5,
  parameter int OPW  = 4,
  parameter int TOGW = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            decValid,
  input logic            decUseRs1,
  input logic            decUseRs2,
  input logic [RW-1:0]   decRs1,
  input logic [RW-1:0]   decRs2,
  input logic            stall,
  input logic [XW-1:0]   exOpA,
  input logic            idexRegWe,
  input logic            idexMemWe,
  input logic            idexMemRe,
  input logic [OPW-1:0]  idexAluOp,
  input logic [RW-1:0]   idexRd,
  input logic [RW-1:0]   idexRs1,
  input logic [RW-1:0]   idexRs2,
  input logic            exmRegWe,
  input logic            exmMemRe,
  input logic [RW-1:0]   exmRd,
  input logic [XW-1:0]   exmResult,
  input logic            wbRegWe,
  input logic [TOGW-1:0] idexTog,
  input logic [TOGW-1:0] exmTog,
  input logic [TOGW-1:0] wbTog
);

  // R1
  load_use_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && idexRegWe && idexMemRe &&
     ((decUseRs1 && decRs1 == idexRd) || (decUseRs2 && decRs2 == idexRd))) |-> stall);

  // R10
  idle_no_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    !decValid |-> !stall);

  // R2
  single_bubble_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> !stall);

  // R3
  bubble_kill_crit_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> (!idexRegWe && !idexMemWe && !idexMemRe));

  // R4
  bubble_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ($stable(idexAluOp) && $stable(idexRd) && $stable(idexRs1) &&
               $stable(idexRs2) && idexTog == '0));

  // R5
  downstream_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> ##1 (exmTog == '0 && !exmRegWe) ##1 (wbTog == '0 && !wbRegWe));

  // R6
  fwd_exm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (exmRegWe && !exmMemRe && exmRd == idexRs1) |-> exOpA == exmResult);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (!idexRegWe && !exmRegWe && !wbRegWe &&
               idexTog == '0 && exmTog == '0 && wbTog == '0));

endmodule

bind lt_bubble_pipe bp_checker #(.XW(XW), .RW(RW), .OPW(OPW), .TOGW(TOGW)) u_chk (
  .clk(clk), .rstN(rstN), .decValid(decValid), .decUseRs1(decUseRs1),
  .decUseRs2(decUseRs2), .decRs1(decRs1), .decRs2(decRs2), .stall(stall),
  .exOpA(exOpA), .idexRegWe(idexRegWe), .idexMemWe(idexMemWe),
  .idexMemRe(idexMemRe), .idexAluOp(idexAluOp), .idexRd(idexRd),
  .idexRs1(idexRs1), .idexRs2(idexRs2), .exmRegWe(exmRegWe),
  .exmMemRe(exmMemRe), .exmRd(exmRd), .exmResult(exmResult),
  .wbRegWe(wbRegWe), .idexTog(idexTog), .exmTog(exmTog), .wbTog(wbTog)
);

// File: tb/tb_lt_bubble_pipe.sv
module tb_lt_bubble_pipe;

  localparam int XW   = 16;
  localparam int RW   = 3;
  localparam int OPW  = 2;
  localparam int TOGW = 8;
  localparam int DW1  = OPW + 3*RW + 2*XW;
  localparam int N    = 160;

  logic clk = 1'b0;
  logic rstN;
  always #2 clk = ~clk;  // 250 MHz

  logic            decValid, decRegWe, decMemWe, decMemRe, decUseRs1, decUseRs2;
  logic [OPW-1:0]  decAluOp;
  logic [RW-1:0]   decRd, decRs1, decRs2;
  logic [XW-1:0]   decOpA, decOpB, exResult, memRdata;
  logic            stall;
  logic [XW-1:0]   exOpA, exOpB;
  logic            idexRegWe, idexMemWe, idexMemRe;
  logic [OPW-1:0]  idexAluOp;
  logic [RW-1:0]   idexRd, idexRs1, idexRs2;
  logic            exmRegWe, exmMemWe, exmMemRe;
  logic [RW-1:0]   exmRd;
  logic [XW-1:0]   exmResult, exmStoreData;
  logic            wbRegWe;
  logic [RW-1:0]   wbRd;
  logic [XW-1:0]   wbData;
  logic [TOGW-1:0] idexTog, exmTog, wbTog;

  lt_bubble_pipe #(.XW(XW), .RW(RW), .OPW(OPW), .TOGW(TOGW)) dut (.*);

  // Behavioural ALU and memory outside the block.
  function automatic logic [XW-1:0] aluF(input logic [OPW-1:0] op,
                                         input logic [XW-1:0] a, input logic [XW-1:0] b);
    case (op)
      2'd0:    return a + b;
      2'd1:    return a ^ b;
      2'd2:    return a - b;
      default: return a;
    endcase
  endfunction
  function automatic logic [XW-1:0] memF(input logic [XW-1:0] addr);
    return XW'(addr * 7) + 16'h1234;
  endfunction

  assign exResult = aluF(idexAluOp, exOpA, exOpB);
  assign memRdata = memF(exmResult);

  // Register file outside the block, written from the writeback port.
  logic [XW-1:0] rf [8];
  always @(posedge clk) if (wbRegWe) rf[wbRd] <= wbData;
  always_comb begin
    decOpA = (wbRegWe && wbRd == decRs1) ? wbData : rf[decRs1];
    decOpB = (wbRegWe && wbRd == decRs2) ? wbData : rf[decRs2];
  end

  // Instruction stream. kind: 0 ALU, 1 load, 2 store, 3 pass-A using source 1 only.
  int kindA [N];
  int rdA [N], rs1A [N], rs2A [N], opA_ [N];
  bit idleA [N];

  logic [RW+XW-1:0]   wbQ [$];
  logic [2*XW-1:0]    stQ [$];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic setI(input int i, input int k, input int d, input int s1, input int s2,
                      input int op);
    kindA[i] = k; rdA[i] = d; rs1A[i] = s1; rs2A[i] = s2;
    opA_[i] = (k == 0) ? op : 3;
  endtask

  // Sequential reference: one instruction at a time, no pipeline.
  task automatic buildRef();
    logic [XW-1:0] regs [8];
    for (int r = 0; r < 8; r++) regs[r] = XW'(r * 3 + 1);
    for (int i = 0; i < N; i++) begin
      logic [XW-1:0] a, b, v;
      a = regs[rs1A[i]];
      b = regs[rs2A[i]];
      case (kindA[i])
        1: begin v = memF(a); regs[rdA[i]] = v; wbQ.push_back({RW'(rdA[i]), v}); end
        2: stQ.push_back({a, b});
        default: begin
          v = aluF(OPW'(opA_[i]), a, b);
          regs[rdA[i]] = v;
          wbQ.push_back({RW'(rdA[i]), v});
        end
      endcase
    end
  endtask

  bit [2:0]        killHist;
  logic [DW1-1:0]  expField;
  int              expTog;

  task automatic postEdgeChecks();
    // R9 toggle count of the decode/execute wide part
    chk(idexTog == TOGW'(expTog), "R9 idexTog", idexTog, expTog);
    if (killHist[0]) begin
      chk(!idexRegWe && !idexMemWe && !idexMemRe, "R3 crit cleared",
          {idexRegWe, idexMemWe, idexMemRe}, 0);
      chk(idexTog == 0, "R4 idexTog zero", idexTog, 0);
      chk(idexAluOp == expField[DW1-1 -: OPW] && idexRd == expField[DW1-OPW-1 -: RW],
          "R4 held fields", {idexAluOp, idexRd}, expField[DW1-1 -: OPW+RW]);
    end
    if (killHist[1])
      chk(exmTog == 0 && !exmRegWe && !exmMemWe, "R5 exm hold", {exmTog, exmRegWe}, 0);
    if (killHist[2])
      chk(wbTog == 0 && !wbRegWe, "R5 wb hold", {wbTog, wbRegWe}, 0);
    if (wbRegWe) begin
      logic [RW+XW-1:0] e;
      e = (wbQ.size() > 0) ? wbQ.pop_front() : '1;
      chk({wbRd, wbData} == e, "R7 writeback (R6 forwarding)", {wbRd, wbData}, e);
    end
    if (exmMemWe) begin
      logic [2*XW-1:0] e;
      e = (stQ.size() > 0) ? stQ.pop_front() : '1;
      chk({exmResult, exmStoreData} == e, "R7 store (R6 forwarding)",
          {exmResult, exmStoreData}, e);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    bit prevLoad = 1'b0, lastStall = 1'b0, idleUsedHere = 1'b0;
    int prevRd = 0, pc = 0, drain = 0;
    logic [15:0] lfsr = 16'hACE1;

    // Directed prefix (ALU ops 0 add, 1 xor, 2 sub).
    setI(0, 1, 1, 2, 0, 0);   // load r1
    setI(1, 0, 3, 1, 4, 0);   // uses r1 via source 1 -> stall
    setI(2, 1, 5, 1, 0, 0);   // load r5
    setI(3, 0, 6, 4, 5, 1);   // uses r5 via source 2 -> stall
    setI(4, 1, 2, 6, 0, 0);   // load r2
    setI(5, 3, 7, 3, 2, 0);   // r2 only in unused source field -> no stall
    setI(6, 1, 4, 7, 0, 0);   // load r4
    setI(7, 0, 1, 6, 3, 2);   // independent -> no stall
    setI(8, 1, 3, 4, 0, 0);   // load r3
    setI(9, 2, 0, 1, 3, 0);   // store data r3 -> stall
    setI(10, 1, 5, 3, 0, 0);  // load chain
    setI(11, 1, 6, 5, 0, 0);
    setI(12, 0, 7, 6, 6, 0);
    for (int i = 0; i < N; i++) idleA[i] = 1'b0;
    idleA[8] = 1'b1; idleA[11] = 1'b1;
    for (int i = 13; i < N; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      setI(i, int'(lfsr[1:0]), int'(lfsr[4:2]), int'(lfsr[7:5]), int'(lfsr[10:8]),
           int'(lfsr[12:11]) % 3);
      idleA[i] = (lfsr[15:13] == 3'd5);
    end
    buildRef();
    for (int r = 0; r < 8; r++) rf[r] = XW'(r * 3 + 1);

    rstN = 1'b0; decValid = 1'b0; decRegWe = 0; decMemWe = 0; decMemRe = 0;
    decUseRs1 = 0; decUseRs2 = 0; decAluOp = '0; decRd = '0; decRs1 = '0; decRs2 = '0;
    killHist = '0; expField = '0; expTog = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8 reset state
    chk(!idexRegWe && !idexMemWe && !idexMemRe && !exmRegWe && !exmMemWe && !wbRegWe,
        "R8 crit reset", {idexRegWe, exmRegWe, wbRegWe}, 0);
    chk(idexTog == 0 && exmTog == 0 && wbTog == 0, "R8 toggles reset",
        {idexTog, exmTog, wbTog}, 0);
    chk(idexRd == 0 && exmResult == 0 && wbData == 0 && !stall, "R8 data reset",
        {idexRd, exmResult, wbData}, 0);
    rstN = 1'b1;

    while (pc < N || drain < 8) begin
      bit idle, expStall, kill;
      logic [DW1-1:0] newField;
      @(negedge clk);
      postEdgeChecks();
      idle = (pc >= N) || (idleA[pc] && !idleUsedHere);
      if (pc < N) begin
        decRegWe  = (kindA[pc] != 2);
        decMemWe  = (kindA[pc] == 2);
        decMemRe  = (kindA[pc] == 1);
        decUseRs1 = 1'b1;
        decUseRs2 = (kindA[pc] == 0) || (kindA[pc] == 2);
        decAluOp  = OPW'(opA_[pc]);
        decRd     = RW'(rdA[pc]);
        decRs1    = RW'(rs1A[pc]);
        decRs2    = RW'(rs2A[pc]);
      end
      decValid = !idle;
      #1;
      expStall = !idle && prevLoad &&
                 ((decUseRs1 && int'(decRs1) == prevRd) || (decUseRs2 && int'(decRs2) == prevRd));
      if (idle) chk(stall == 1'b0, "R10 idle slot stall", stall, 0);
      else      chk(stall == expStall, "R1 load-use stall", stall, expStall);
      if (stall && lastStall) chk(1'b0, "R2 repeated stall", 1, 0);
      lastStall = stall;
      kill = idle || expStall;
      newField = kill ? expField : {decAluOp, decRd, decRs1, decRs2, decOpA, decOpB};
      expTog = $countones(newField ^ expField);
      expField = newField;
      killHist = {killHist[1:0], kill};
      if (idle) begin
        prevLoad = 1'b0;
        if (pc < N) idleUsedHere = 1'b1; else drain++;
      end else if (expStall) begin
        prevLoad = 1'b0;
      end else begin
        prevLoad = (kindA[pc] == 1);
        prevRd = rdA[pc];
        pc++;
        idleUsedHere = 1'b0;
      end
    end
    @(negedge clk);
    postEdgeChecks();
    chk(wbQ.size() == 0 && stQ.size() == 0, "R7 all results seen",
        wbQ.size() + stQ.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule